// File: doc/BRIEF.md
# Fault Flag and Dead-Time Sense Register

This block is the status and acknowledge register of a six-output motor-control PWM unit. It watches four external fault pins and records each rising edge as a sticky flag. A flag stays set until software clears it by writing a 1 to that flag's acknowledge bit. The register port is a single 8-bit location. Writes to it carry the acknowledge field. Reads from it return six dead-time bits.

Each dead-time bit records the level of one of three current-sense inputs. The bit is sampled in the cycle where the PWM generator signals that dead-time is ending for its channel. Software reads these bits to check that the current-sense path behaves as intended around each switching event. The fault flags are also presented on a separate 4-bit status output. Fault and sense inputs are asynchronous and are brought into the clock domain inside the block.

Top module: `fault_sense_reg`

## Requirements
- R1: A fault flag reads 1 after the second rising clock edge following a low-to-high change on its fault pin. It still reads 0 after the first of those edges.
- R2: A set fault flag stays set across writes whose acknowledge bit for that flag is 0.
- R3: A write with data bit 4+i at 1 clears fault flag i at that clock edge. Bit 4 maps to fault 0 and bit 7 maps to fault 3.
- R4: Read data bits 7 and 6 are always 0, and bits 5..0 are dead-time bits 5..0. Acknowledge bits are never readable, and a write leaves the read data unchanged.
- R5: A dead-time-end strobe on channel c loads dead-time bit c with the synchronized level of current-sense input c/2 (integer division). Channels 0 and 1 use sense 0, channels 2 and 3 use sense 1, and channels 4 and 5 use sense 2.
- R6: A dead-time bit holds its value until the next strobe on its own channel, however the sense inputs change.
- R7: When a fault edge and an acknowledge of the same flag fall in the same cycle, the flag ends up set.
- R8: Flags are set by edges and not by levels. A fault pin held high after its flag is acknowledged does not set the flag again.
- R9: After reset, all fault flags and all read data bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register location |
| reg_wdata | input | 8 | Write data; bits 7..4 are the acknowledge field |
| reg_rdata | output | 8 | Read data: zeros in bits 7..6, dead-time bits in 5..0 |
| fault_in | input | 4 | Asynchronous fault pins, one per flag |
| sense_in | input | 3 | Asynchronous current-sense inputs |
| dt_end | input | 6 | One-cycle dead-time-end strobes, one per PWM channel |
| fault_flags | output | 4 | Sticky fault flags |

## Verification
On every cycle, the assertions check three things. A flag never rises unless its pin was high two samples earlier. A flag that is set and not acknowledged stays set. The upper read bits stay zero, and the dead-time bits do not move in a cycle without a strobe. The bench scenarios cover what needs a planned sequence of stimulus: the exact two-edge set latency, the mapping of acknowledge bits to flags, and set winning over an acknowledge in the same cycle. They also cover the absence of re-triggering while a pin is held high, and the channel-to-sense mapping with hold-until-next-strobe.

// File: rtl/fs_pkg.sv
// Shared helpers for the fault flag and dead-time sense register.
// Assumes channel count is an integer multiple of the sense input count.
package fs_pkg;

    // Maps a PWM channel to the current-sense input that serves it.
    function automatic int unsigned sense_of_channel(input int unsigned ch,
                                                     input int unsigned ch_per_sense);
        return ch / ch_per_sense;
    endfunction

endpackage

// File: rtl/fs_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is provided.
module fs_sync #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [DEPTH];

    // Shift the input through DEPTH flops, clearing them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/fs_fault_latch.sv
// Sticky fault flags with edge detection on asynchronous pins.
// Two flops per pin: a capture stage and a settled stage. The edge is
// taken between them, so a flag is visible two clock edges after a pin
// rises. A set request beats an acknowledge in the same cycle.
module fs_fault_latch #(
    parameter int unsigned NUM_FAULTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] pin,
    input  logic [NUM_FAULTS-1:0] ack,
    output logic [NUM_FAULTS-1:0] flags
);

    logic [NUM_FAULTS-1:0] cap_q;
    logic [NUM_FAULTS-1:0] settled_q;
    logic [NUM_FAULTS-1:0] rise;

    // Bring the pins into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            settled_q <= '0;
        end else begin
            cap_q     <= pin;
            settled_q <= cap_q;
        end
    end

    // A low-to-high transition seen across the two stages.
    always_comb rise = cap_q & ~settled_q;

    // Hold flags until acknowledged; a new edge always wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~ack) | rise;
    end

endmodule

// File: rtl/fs_dt_capture.sv
// Dead-time sense snapshot: one bit per PWM channel, loaded from the
// channel's current-sense input when that channel's strobe pulses.
// Assumes sense inputs arrive already synchronized and strobes are
// single-cycle pulses.
module fs_dt_capture #(
    parameter int unsigned NUM_CH    = 6,
    parameter int unsigned NUM_SENSE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SENSE-1:0] sense_s,
    input  logic [NUM_CH-1:0]    strobe,
    output logic [NUM_CH-1:0]    dt_bits
);
    import fs_pkg::*;

    localparam int unsigned CH_PER_SENSE = NUM_CH / NUM_SENSE;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned SIDX = sense_of_channel(c, CH_PER_SENSE);

        // Load the served sense level on this channel's strobe, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)         dt_bits[c] <= 1'b0;
            else if (strobe[c]) dt_bits[c] <= sense_s[SIDX];
        end
    end

endmodule

// File: rtl/fault_sense_reg.sv
// Fault flag and dead-time sense register, top level.
// One 8-bit location: writes carry acknowledge bits in the top nibble,
// reads return dead-time snapshots in the low bits. Fault flags also
// drive a status output. Assumes dt_end pulses are one cycle long.
module fault_sense_reg #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_FAULTS = 4,
    parameter int unsigned NUM_SENSE  = 3,
    parameter int unsigned NUM_CH     = 6,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_FAULTS-1:0] fault_in,
    input  logic [NUM_SENSE-1:0]  sense_in,
    input  logic [NUM_CH-1:0]     dt_end,
    output logic [NUM_FAULTS-1:0] fault_flags
);

    localparam int unsigned ACK_LSB = DATA_W - NUM_FAULTS;
    localparam int unsigned PAD_W   = DATA_W - NUM_CH;

    logic [NUM_FAULTS-1:0] ack;
    logic [NUM_SENSE-1:0]  sense_s;
    logic [NUM_CH-1:0]     dt_bits;
    logic                  wdata_unused;

    // Acknowledge mask: a write with a 1 in the field clears that flag.
    always_comb ack = reg_wr ? reg_wdata[DATA_W-1:ACK_LSB] : '0;

    // Low write bits carry nothing.
    assign wdata_unused = ^reg_wdata[ACK_LSB-1:0];

    fs_sync #(.WIDTH(NUM_SENSE), .DEPTH(SYNC_DEPTH)) u_sense_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sense_in),
        .q     (sense_s)
    );

    fs_fault_latch #(.NUM_FAULTS(NUM_FAULTS)) u_faults (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (fault_in),
        .ack   (ack),
        .flags (fault_flags)
    );

    fs_dt_capture #(.NUM_CH(NUM_CH), .NUM_SENSE(NUM_SENSE)) u_dt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_s (sense_s),
        .strobe  (dt_end),
        .dt_bits (dt_bits)
    );

    // Read view: zero padding above the dead-time snapshots.
    always_comb reg_rdata = {{PAD_W{1'b0}}, dt_bits};

endmodule

// File: rtl/fs_reg_checker.sv
// Protocol checker for fault_sense_reg, attached through bind.
module fs_reg_checker #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_FAULTS = 4,
    parameter int unsigned NUM_CH     = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic [NUM_FAULTS-1:0] fault_in,
    input logic [NUM_CH-1:0]     dt_end,
    input logic [NUM_FAULTS-1:0] fault_flags
);
    localparam int unsigned ACK_LSB = DATA_W - NUM_FAULTS;

    logic [NUM_FAULTS-1:0] ack_w;
    logic [NUM_FAULTS-1:0] keep;

    always_comb ack_w = reg_wr ? reg_wdata[DATA_W-1:ACK_LSB] : '0;
    always_comb keep  = fault_flags & ~ack_w;

    // R1: a flag only rises if its pin was high two samples earlier.
    p_rise_needs_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_flags & ~$past(fault_flags)) & ~$past(fault_in, 2)) == '0);

    // R2: an unacknowledged set flag stays set.
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (keep != '0) |=> ((fault_flags & $past(keep)) == $past(keep)));

    // R4: padding bits of the read data are zero.
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_CH] == '0);

    // R6: without a strobe, the dead-time bits do not move.
    p_dt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_end == '0) |=> $stable(reg_rdata[NUM_CH-1:0]));

endmodule

bind fault_sense_reg fs_reg_checker #(
    .DATA_W(DATA_W), .NUM_FAULTS(NUM_FAULTS), .NUM_CH(NUM_CH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .fault_in    (fault_in),
    .dt_end      (dt_end),
    .fault_flags (fault_flags)
);

// File: tb/sim_fault_sense_reg.sv
// Directed bench for fault_sense_reg: one task per scenario.
module sim_fault_sense_reg;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] fault_in = '0;
    logic [2:0] sense_in = '0;
    logic [5:0] dt_end = '0;
    logic [3:0] fault_flags;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fault_sense_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fault_in(fault_in), .sense_in(sense_in),
        .dt_end(dt_end), .fault_flags(fault_flags)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance n edges and sample just after the last.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One-cycle register write; sampled after the capturing edge.
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        tick(1);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R9 flags", {4'h0, fault_flags}, 8'h00);
        chk("R9 rdata", reg_rdata, 8'h00);
    endtask

    task automatic t_latency_and_ack();
        @(negedge clk); fault_in[0] = 1'b1;
        tick(1);
        chk("R1 first edge", {4'h0, fault_flags}, 8'h00);
        tick(1);
        chk("R1 second edge", {4'h0, fault_flags}, 8'h01);
        wr(8'h00);
        chk("R2 zero ack", {4'h0, fault_flags}, 8'h01);
        wr(8'hE0);
        chk("R2 other acks", {4'h0, fault_flags}, 8'h01);
        wr(8'h10);
        chk("R3 ack bit4", {4'h0, fault_flags}, 8'h00);
        tick(4);
        chk("R8 held pin", {4'h0, fault_flags}, 8'h00);
        @(negedge clk); fault_in[0] = 1'b0;
    endtask

    task automatic t_multi_ack();
        @(negedge clk); fault_in[3] = 1'b1; fault_in[1] = 1'b1;
        tick(3);
        chk("R1 two pins", {4'h0, fault_flags}, 8'h0A);
        wr(8'h80);
        chk("R3 ack bit7", {4'h0, fault_flags}, 8'h02);
        wr(8'h20);
        chk("R3 ack bit5", {4'h0, fault_flags}, 8'h00);
        @(negedge clk); fault_in = '0;
    endtask

    task automatic t_set_wins();
        @(negedge clk); fault_in[2] = 1'b1;
        tick(1);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h40;
        tick(1);
        chk("R7 set beats ack", {4'h0, fault_flags}, 8'h04);
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        wr(8'h40);
        chk("R3 ack bit6", {4'h0, fault_flags}, 8'h00);
        @(negedge clk); fault_in = '0;
    endtask

    task automatic strobe(input logic [5:0] s);
        @(negedge clk); dt_end = s;
        tick(1);
        @(negedge clk); dt_end = '0;
    endtask

    task automatic t_dead_time();
        @(negedge clk); sense_in = 3'b101;
        tick(3);
        strobe(6'b111111);
        chk("R5 all channels", reg_rdata, 8'h33);
        @(negedge clk); sense_in = 3'b010;
        tick(3);
        chk("R6 hold on sense change", reg_rdata, 8'h33);
        strobe(6'b000100);
        chk("R5 channel2 uses sense1", reg_rdata, 8'h37);
        strobe(6'b010000);
        chk("R6 channel4 reloads", reg_rdata, 8'h27);
        wr(8'hFF);
        chk("R4 write leaves read", reg_rdata, 8'h27);
        chk("R4 write on clear flags", {4'h0, fault_flags}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_latency_and_ack();
        t_multi_ack();
        t_set_wins();
        t_dead_time();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule